// File: doc/BRIEF.md
# Programmable Interlaced Sync Generator

This block derives the horizontal and vertical timing of a video raster from a single sync-generator clock. Every timing value arrives on configuration inputs that count in half units: the horizontal total is the number of clocks in half a line, and the vertical total is the number of half-lines in one field. When the vertical total is odd, each field ends halfway along a line and the field number alternates, which gives interlaced timing. When the total is even, the raster is progressive and the field number shown is a programmed constant.

Horizontal blanking begins a programmed distance after mid-line and ends a programmed distance after the line wraps. The display window opens a programmed distance after the line wraps and closes a programmed distance after mid-line. Active video is the part of the raster that is not blanked. Where active video lies outside the display window, the block flags border. A colour-burst gate is placed a programmed offset after blank start. The block also reports the current line number, the field number and a raw vertical-sync status. One enable bit forces every sync-type output to its inactive level.

Top module: `isync_gen`

## Requirements
- R1: The horizontal count runs from 0 to 2*cfg_htotal-1 and then returns to 0. hsync is high while the count is below 2*cfg_hsync_half.
- R2: The half-line count advances at count cfg_htotal-1 and at count 2*cfg_htotal-1. It returns to 0 after the value cfg_vtotal-1. vsync is high while the half-line count is below cfg_vsync2.
- R3: hblank is high when the horizontal count is at least cfg_htotal+cfg_hbstart, or when it is below cfg_hbend.
- R4: vblank is high while the half-line count is below cfg_vbend.
- R5: The display window is the set of counts h and half-line counts v with cfg_hdstart <= h < cfg_htotal+cfg_hdend and cfg_vdstart <= v < cfg_vdend. disp_active is high inside the window when neither horizontal nor vertical blanking is in effect.
- R6: border is high when neither horizontal nor vertical blanking is in effect and the position lies outside the display window. border and disp_active are never high together.
- R7: Let the burst start be b = cfg_htotal+cfg_hbstart+cfg_burst_start. burst is high while b <= h < b+cfg_burst_width.
- R8: With an odd cfg_vtotal, field (2 bits) reads 0 in the first field after reset and alternates between 0 and 1 at each field wrap. With an even cfg_vtotal, field equals cfg_ni_field.
- R9: line_num (10 bits) is the half-line count divided by two.
- R10: csync equals hsync OR vsync. While cfg_sync_en is 0, the outputs hsync, vsync, csync, hblank, vblank and burst stay 0. vsync_state always shows the ungated vertical sync.
- R11: While rst_n is low, every output is 0. After rst_n is released, the outputs present count state 0 (h=0, v=0) from the third rising clock edge. After that they advance by one state per clock, so every output lags its counters by one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sync-generator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_htotal | input | 9 | Clocks per half line |
| cfg_vtotal | input | 11 | Half-lines per field; an odd value selects interlace |
| cfg_vsync2 | input | 4 | Vertical sync length in half-lines |
| cfg_hsync_half | input | 6 | Half the hsync width in clocks |
| cfg_hbstart | input | 9 | Blank start, in clocks after mid-line |
| cfg_hbend | input | 9 | Blank end, in clocks after line wrap |
| cfg_hdstart | input | 10 | Display start, in clocks after line wrap |
| cfg_hdend | input | 10 | Display stop, in clocks after mid-line |
| cfg_vbend | input | 11 | Vertical blank length in half-lines |
| cfg_vdstart | input | 11 | First displayed half-line |
| cfg_vdend | input | 11 | Half-line at which display stops |
| cfg_burst_start | input | 7 | Burst offset after blank start |
| cfg_burst_width | input | 6 | Burst length in clocks |
| cfg_sync_en | input | 1 | 0 holds the sync-type outputs inactive |
| cfg_ni_field | input | 2 | Field number shown when progressive |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| csync | output | 1 | Composite sync |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |
| disp_active | output | 1 | Inside the display window and unblanked |
| border | output | 1 | Unblanked but outside the display window |
| burst | output | 1 | Colour-burst gate |
| vsync_state | output | 1 | Ungated vertical sync status |
| field | output | 2 | Current field number |
| line_num | output | 10 | Current line number |

## Verification
The checker applies a set of relations on every clock:
- a disabled enable silences the sync-type outputs one cycle later;
- burst only occurs inside horizontal blanking;
- display and border exclude each other, and display never overlaps blanking;
- the line number only steps up by one or returns to zero;
- a progressive total yields the programmed field number.

Only the bench's scenarios can show the exact positions of the edges. These include hsync width, blank and window edges measured from mid-line or line end, burst placement, sync length in half-lines, and field alternation at a mid-line wrap. The bench compares them against a closed-form position model across interlaced, progressive and disabled configurations.

// File: rtl/isg_pkg.sv
package isg_pkg;
  localparam int unsigned HW_DEF  = 9;
  localparam int unsigned VW_DEF  = 11;
  localparam int unsigned HSW_DEF = 6;
  localparam int unsigned VSW_DEF = 4;
  localparam int unsigned BSW_DEF = 7;
  localparam int unsigned BWW_DEF = 6;

  typedef struct packed {
    logic hs;
    logic vs;
    logic hb;
    logic vb;
    logic disp;
    logic bord;
    logic bu;
  } isg_flags_t;
endpackage

// File: rtl/isg_rst_sync.sv
module isg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync = s2_q;
endmodule

// File: rtl/isg_counters.sv
module isg_counters #(
  parameter int unsigned HW = 9,
  parameter int unsigned VW = 11
) (
  input  logic          clk,
  input  logic          rst_sync,
  input  logic [HW-1:0] cfg_htotal,
  input  logic [VW-1:0] cfg_vtotal,
  output logic [HW:0]   hcnt,
  output logic [VW-1:0] vhalf,
  output logic          fld
);
  localparam int unsigned HCW = HW + 1;

  logic [HCW-1:0] hcnt_d;
  logic [VW-1:0]  vhalf_d;
  logic           fld_d;
  logic           h_last, h_step, v_last;

  always_comb begin
    h_last  = (hcnt >= ({cfg_htotal, 1'b0} - HCW'(1)));
    h_step  = h_last || (hcnt == ({1'b0, cfg_htotal} - HCW'(1)));
    v_last  = (vhalf >= (cfg_vtotal - VW'(1)));
    hcnt_d  = h_last ? '0 : hcnt + HCW'(1);
    vhalf_d = vhalf;
    fld_d   = fld;
    if (h_step) begin
      if (v_last) begin
        vhalf_d = '0;
        fld_d   = fld ^ cfg_vtotal[0];
      end else begin
        vhalf_d = vhalf + VW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      hcnt  <= '0;
      vhalf <= '0;
      fld   <= 1'b0;
    end else begin
      hcnt  <= hcnt_d;
      vhalf <= vhalf_d;
      fld   <= fld_d;
    end
  end
endmodule

// File: rtl/isg_decode.sv
module isg_decode
  import isg_pkg::*;
#(
  parameter int unsigned HW  = 9,
  parameter int unsigned VW  = 11,
  parameter int unsigned HSW = 6,
  parameter int unsigned VSW = 4,
  parameter int unsigned BSW = 7,
  parameter int unsigned BWW = 6
) (
  input  logic [HW:0]    hcnt,
  input  logic [VW-1:0]  vhalf,
  input  logic [HW-1:0]  cfg_htotal,
  input  logic [VSW-1:0] cfg_vsync2,
  input  logic [HSW-1:0] cfg_hsync_half,
  input  logic [HW-1:0]  cfg_hbstart,
  input  logic [HW-1:0]  cfg_hbend,
  input  logic [HW:0]    cfg_hdstart,
  input  logic [HW:0]    cfg_hdend,
  input  logic [VW-1:0]  cfg_vbend,
  input  logic [VW-1:0]  cfg_vdstart,
  input  logic [VW-1:0]  cfg_vdend,
  input  logic [BSW-1:0] cfg_burst_start,
  input  logic [BWW-1:0] cfg_burst_width,
  output isg_flags_t     flags
);
  localparam int unsigned EW = HW + 3;

  logic [EW-1:0] hc, mid, hb_at, bu_at;
  logic          hwin, vwin, act;

  always_comb begin
    hc    = EW'(hcnt);
    mid   = EW'(cfg_htotal);
    hb_at = mid + EW'(cfg_hbstart);
    bu_at = hb_at + EW'(cfg_burst_start);
    hwin  = (hc >= EW'(cfg_hdstart)) && (hc < mid + EW'(cfg_hdend));
    vwin  = (vhalf >= cfg_vdstart) && (vhalf < cfg_vdend);

    flags.hs   = hc < EW'({cfg_hsync_half, 1'b0});
    flags.vs   = vhalf < VW'(cfg_vsync2);
    flags.hb   = (hc >= hb_at) || (hc < EW'(cfg_hbend));
    flags.vb   = vhalf < cfg_vbend;
    act        = !flags.hb && !flags.vb;
    flags.disp = act && hwin && vwin;
    flags.bord = act && !(hwin && vwin);
    flags.bu   = (hc >= bu_at) && (hc < bu_at + EW'(cfg_burst_width));
  end
endmodule

// File: rtl/isync_gen.sv
module isync_gen
  import isg_pkg::*;
#(
  parameter int unsigned HW  = HW_DEF,
  parameter int unsigned VW  = VW_DEF,
  parameter int unsigned HSW = HSW_DEF,
  parameter int unsigned VSW = VSW_DEF,
  parameter int unsigned BSW = BSW_DEF,
  parameter int unsigned BWW = BWW_DEF
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [HW-1:0]  cfg_htotal,
  input  logic [VW-1:0]  cfg_vtotal,
  input  logic [VSW-1:0] cfg_vsync2,
  input  logic [HSW-1:0] cfg_hsync_half,
  input  logic [HW-1:0]  cfg_hbstart,
  input  logic [HW-1:0]  cfg_hbend,
  input  logic [HW:0]    cfg_hdstart,
  input  logic [HW:0]    cfg_hdend,
  input  logic [VW-1:0]  cfg_vbend,
  input  logic [VW-1:0]  cfg_vdstart,
  input  logic [VW-1:0]  cfg_vdend,
  input  logic [BSW-1:0] cfg_burst_start,
  input  logic [BWW-1:0] cfg_burst_width,
  input  logic           cfg_sync_en,
  input  logic [1:0]     cfg_ni_field,
  output logic           hsync,
  output logic           vsync,
  output logic           csync,
  output logic           hblank,
  output logic           vblank,
  output logic           disp_active,
  output logic           border,
  output logic           burst,
  output logic           vsync_state,
  output logic [1:0]     field,
  output logic [VW-2:0]  line_num
);
  localparam int unsigned LW = VW - 1;

  logic          rst_sync;
  logic [HW:0]   hcnt;
  logic [VW-1:0] vhalf;
  logic          fld;
  isg_flags_t    flags;

  logic          hs_d, vs_d, cs_d, hb_d, vb_d, bu_d;
  logic [1:0]    field_d;

  isg_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync(rst_sync));

  isg_counters #(.HW(HW), .VW(VW)) u_cnt (
    .clk(clk), .rst_sync(rst_sync),
    .cfg_htotal(cfg_htotal), .cfg_vtotal(cfg_vtotal),
    .hcnt(hcnt), .vhalf(vhalf), .fld(fld)
  );

  isg_decode #(.HW(HW), .VW(VW), .HSW(HSW), .VSW(VSW), .BSW(BSW), .BWW(BWW)) u_dec (
    .hcnt(hcnt), .vhalf(vhalf), .cfg_htotal(cfg_htotal),
    .cfg_vsync2(cfg_vsync2), .cfg_hsync_half(cfg_hsync_half),
    .cfg_hbstart(cfg_hbstart), .cfg_hbend(cfg_hbend),
    .cfg_hdstart(cfg_hdstart), .cfg_hdend(cfg_hdend),
    .cfg_vbend(cfg_vbend), .cfg_vdstart(cfg_vdstart), .cfg_vdend(cfg_vdend),
    .cfg_burst_start(cfg_burst_start), .cfg_burst_width(cfg_burst_width),
    .flags(flags)
  );

  always_comb begin
    hs_d    = cfg_sync_en && flags.hs;
    vs_d    = cfg_sync_en && flags.vs;
    cs_d    = cfg_sync_en && (flags.hs || flags.vs);
    hb_d    = cfg_sync_en && flags.hb;
    vb_d    = cfg_sync_en && flags.vb;
    bu_d    = cfg_sync_en && flags.bu;
    field_d = cfg_vtotal[0] ? {1'b0, fld} : cfg_ni_field;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      hsync       <= 1'b0;
      vsync       <= 1'b0;
      csync       <= 1'b0;
      hblank      <= 1'b0;
      vblank      <= 1'b0;
      disp_active <= 1'b0;
      border      <= 1'b0;
      burst       <= 1'b0;
      vsync_state <= 1'b0;
      field       <= 2'b00;
      line_num    <= '0;
    end else begin
      hsync       <= hs_d;
      vsync       <= vs_d;
      csync       <= cs_d;
      hblank      <= hb_d;
      vblank      <= vb_d;
      disp_active <= flags.disp;
      border      <= flags.bord;
      burst       <= bu_d;
      vsync_state <= flags.vs;
      field       <= field_d;
      line_num    <= vhalf[VW-1:1];
    end
  end

  initial begin
    if (LW != $bits(line_num)) $display("isync_gen: line width mismatch");
  end
endmodule

// File: rtl/isg_checker.sv
module isg_checker #(
  parameter int unsigned VW = 11
) (
  input logic          clk,
  input logic          rst_sync,
  input logic          cfg_sync_en,
  input logic [VW-1:0] cfg_vtotal,
  input logic [1:0]    cfg_ni_field,
  input logic          hsync,
  input logic          vsync,
  input logic          csync,
  input logic          hblank,
  input logic          vblank,
  input logic          disp_active,
  input logic          border,
  input logic          burst,
  input logic [1:0]    field,
  input logic [VW-2:0] line_num
);
  a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_sync)
    !cfg_sync_en |=> (!hsync && !vsync && !csync && !hblank && !vblank && !burst));

  a_r7_burst_in_blank: assert property (@(posedge clk) disable iff (!rst_sync)
    burst |-> hblank);

  a_r6_disp_border_excl: assert property (@(posedge clk) disable iff (!rst_sync)
    !(disp_active && border));

  a_r5_disp_unblanked: assert property (@(posedge clk) disable iff (!rst_sync)
    disp_active |-> (!hblank && !vblank));

  a_r9_line_steps: assert property (@(posedge clk) disable iff (!rst_sync)
    (line_num != $past(line_num)) |-> ((line_num == $past(line_num) + 1'b1) || (line_num == '0)));

  a_r8_prog_field: assert property (@(posedge clk) disable iff (!rst_sync)
    !cfg_vtotal[0] |=> (field == $past(cfg_ni_field)));
endmodule

bind isync_gen isg_checker #(.VW(VW)) u_isg_chk (
  .clk(clk), .rst_sync(rst_sync), .cfg_sync_en(cfg_sync_en),
  .cfg_vtotal(cfg_vtotal), .cfg_ni_field(cfg_ni_field),
  .hsync(hsync), .vsync(vsync), .csync(csync), .hblank(hblank),
  .vblank(vblank), .disp_active(disp_active), .border(border),
  .burst(burst), .field(field), .line_num(line_num)
);

// File: tb/test_isync_gen.sv
module test_isync_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NROWS = 4;

  typedef struct packed {
    logic [8:0]  ht;
    logic [10:0] vt;
    logic [3:0]  vs2;
    logic [5:0]  hsh;
    logic [8:0]  hbs;
    logic [8:0]  hbe;
    logic [9:0]  hds;
    logic [9:0]  hde;
    logic [10:0] vbe;
    logic [10:0] vds;
    logic [10:0] vde;
    logic [6:0]  bst;
    logic [5:0]  bw;
    logic        en;
    logic [1:0]  ni;
  } cfg_t;

  localparam cfg_t TAB [NROWS] = '{
    '{9'd12, 11'd21, 4'd3, 6'd2, 9'd8, 9'd3, 10'd5, 10'd6, 11'd4, 11'd6, 11'd18, 7'd1, 6'd2, 1'b1, 2'd0},
    '{9'd10, 11'd20, 4'd2, 6'd1, 9'd7, 9'd2, 10'd2, 10'd9, 11'd2, 11'd1, 11'd20, 7'd0, 6'd3, 1'b1, 2'd2},
    '{9'd12, 11'd22, 4'd3, 6'd2, 9'd8, 9'd3, 10'd5, 10'd6, 11'd4, 11'd6, 11'd18, 7'd1, 6'd2, 1'b0, 2'd1},
    '{9'd16, 11'd15, 4'd5, 6'd3, 9'd12, 9'd4, 10'd7, 10'd4, 11'd3, 11'd5, 11'd12, 7'd2, 6'd1, 1'b1, 2'd3}
  };

  logic clk = 1'b0;
  logic rst_n;
  cfg_t cfg;
  logic hsync, vsync, csync, hblank, vblank, disp_active, border, burst, vsync_state;
  logic [1:0] field;
  logic [9:0] line_num;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isync_gen i_isync_gen (
    .clk(clk), .rst_n(rst_n),
    .cfg_htotal(cfg.ht), .cfg_vtotal(cfg.vt), .cfg_vsync2(cfg.vs2),
    .cfg_hsync_half(cfg.hsh), .cfg_hbstart(cfg.hbs), .cfg_hbend(cfg.hbe),
    .cfg_hdstart(cfg.hds), .cfg_hdend(cfg.hde), .cfg_vbend(cfg.vbe),
    .cfg_vdstart(cfg.vds), .cfg_vdend(cfg.vde), .cfg_burst_start(cfg.bst),
    .cfg_burst_width(cfg.bw), .cfg_sync_en(cfg.en), .cfg_ni_field(cfg.ni),
    .hsync(hsync), .vsync(vsync), .csync(csync), .hblank(hblank),
    .vblank(vblank), .disp_active(disp_active), .border(border),
    .burst(burst), .vsync_state(vsync_state), .field(field), .line_num(line_num)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_zero(input string tag);
    chk({tag, " hsync"}, int'(hsync), 0);
    chk({tag, " vsync"}, int'(vsync), 0);
    chk({tag, " csync"}, int'(csync), 0);
    chk({tag, " hblank"}, int'(hblank), 0);
    chk({tag, " vblank"}, int'(vblank), 0);
    chk({tag, " disp"}, int'(disp_active), 0);
    chk({tag, " border"}, int'(border), 0);
    chk({tag, " burst"}, int'(burst), 0);
    chk({tag, " vsync_state"}, int'(vsync_state), 0);
    chk({tag, " field"}, int'(field), 0);
    chk({tag, " line"}, int'(line_num), 0);
  endtask

  // Position model for count state k after reset release.
  task automatic check_state(input int k);
    int ht, vt, hc, h, vh, fld, mid, bz;
    bit hs, vs, hb, vb, hw, vw, act, bu, en;
    ht  = int'(cfg.ht);
    vt  = int'(cfg.vt);
    en  = cfg.en;
    mid = ht;
    hc  = k % (2 * ht);
    h   = k / ht;
    vh  = h % vt;
    fld = (h / vt) % 2;
    hs  = hc < 2 * int'(cfg.hsh);
    vs  = vh < int'(cfg.vs2);
    hb  = (hc >= mid + int'(cfg.hbs)) || (hc < int'(cfg.hbe));
    vb  = vh < int'(cfg.vbe);
    hw  = (hc >= int'(cfg.hds)) && (hc < mid + int'(cfg.hde));
    vw  = (vh >= int'(cfg.vds)) && (vh < int'(cfg.vde));
    act = !hb && !vb;
    bz  = mid + int'(cfg.hbs) + int'(cfg.bst);
    bu  = (hc >= bz) && (hc < bz + int'(cfg.bw));
    chk("R1 hsync", int'(hsync), int'(en && hs));
    chk("R2 vsync", int'(vsync), int'(en && vs));
    chk("R10 csync", int'(csync), int'(en && (hs || vs)));
    chk("R10 vsync_state", int'(vsync_state), int'(vs));
    chk("R3 hblank", int'(hblank), int'(en && hb));
    chk("R4 vblank", int'(vblank), int'(en && vb));
    chk("R5 disp_active", int'(disp_active), int'(act && hw && vw));
    chk("R6 border", int'(border), int'(act && !(hw && vw)));
    chk("R7 burst", int'(burst), int'(en && bu));
    chk("R8 field", int'(field), (vt % 2 == 1) ? fld : int'(cfg.ni));
    chk("R9 line_num", int'(line_num), vh / 2);
  endtask

  task automatic release_and_align();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg = TAB[0];
    for (int r = 0; r < NROWS; r++) begin
      int ncyc;
      rst_n = 1'b0;
      cfg = TAB[r];
      repeat (2) @(negedge clk);
      check_zero("R11 reset");
      release_and_align();
      ncyc = 3 * int'(cfg.vt) * int'(cfg.ht) + 5;
      for (int k = 0; k < ncyc; k++) begin
        check_state(k);
        @(negedge clk);
      end
    end

    // Directed: state 0 visible exactly on the third edge, not earlier (R11).
    cfg = TAB[0];
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_zero("R11 sync window");
    @(posedge clk);
    @(negedge clk);
    check_state(0);
    @(negedge clk);
    check_state(1);

    // Directed: asynchronous reset mid-line clears outputs at once (R11).
    repeat (30) @(negedge clk);
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    check_zero("R11 async");

    // Directed: enable dropped during a running frame silences sync (R10).
    release_and_align();
    repeat (3) @(negedge clk);
    chk("R1 hsync before disable", int'(hsync), 1);
    cfg.en = 1'b0;
    @(negedge clk);
    chk("R10 hsync off", int'(hsync), 0);
    chk("R10 vsync off", int'(vsync), 0);
    chk("R10 vsync_state live", int'(vsync_state), 1);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule